// File: doc/BRIEF.md
# Multi-Source Trigger Alignment Unit

This block gathers trigger requests from eight sources and turns them into one acquisition trigger that lines up with a delayed copy of the sample stream. The sources are four per-channel threshold triggers, one external input, one software strobe and two timer strobes. The threshold triggers are the slowest sources, so they get no compensation. Every other source passes through its own fixed delay line. As a result, an event on any source marks a known sample in the delayed stream.

The external input is asynchronous. It passes through a two-stage synchroniser, a polarity-selectable edge detector and an optional programmable delay before it reaches its fixed delay line. The programmable delay is a down counter. While it runs, a busy flag is high and further external events are dropped. Every source has its own enable, and a disabled source never produces a trigger. The aligned pulses are ORed together and registered once to form the output.

Top module: `trig_align_unit`

## Requirements
- R1: `samp_out` presents the word sampled on `samp_in` exactly 3 clock edges earlier. After reset it reads 0.
- R2: A one-cycle pulse on `int_trig[k]` with `int_en[k]` set raises `trig_out` for one cycle. That cycle is the one in which `samp_out` carries the word sampled together with the pulse, a total latency of 3 cycles.
- R3: An accepted external event with `ext_dly` = 0 raises `trig_out` 10 cycles after the edge on which the new level is first sampled. That is the cycle in which `samp_out` carries the word 7 samples after the one sampled with the event.
- R4: A software strobe raises `trig_out` 12 cycles later, together with the word 9 samples after the one sampled with the strobe.
- R5: The primary timer strobe (`tm_trig`) and the secondary timer strobe (`tm2_trig`) each raise `trig_out` 12 cycles later, together with the word 9 samples after the one sampled with the strobe.
- R6: With `ext_pol` = 0, only a low-to-high transition of `ext_in` is an event. With `ext_pol` = 1, only a high-to-low transition is an event. The opposite transition produces no trigger.
- R7: A nonzero `ext_dly` = N adds exactly N cycles to the external path. `ext_busy` is high for exactly N consecutive cycles, starting 3 clock edges after the edge on which the event is first sampled.
- R8: External events that arrive while `ext_busy` is high are ignored. They neither restart the count nor add a trigger.
- R9: A source whose enable is low produces no trigger. A disabled external input never raises `ext_busy`.
- R10: A single event gives a single one-cycle output pulse, even when `ext_in` holds its active level for many cycles.
- R11: After reset, `trig_out` and `ext_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_in | input | DW | Incoming sample word |
| samp_out | output | DW | Sample word delayed by the data pipeline |
| int_trig | input | NCH | Per-channel threshold trigger pulses |
| int_en | input | NCH | Per-channel threshold trigger enables |
| ext_in | input | 1 | Asynchronous external trigger level |
| ext_pol | input | 1 | 0: rising edge is the event, 1: falling edge |
| ext_en | input | 1 | External trigger enable |
| ext_dly | input | XDLY_W | Programmable external delay in cycles, 0 = none |
| ext_busy | output | 1 | External programmable delay is counting |
| sw_trig | input | 1 | Software trigger strobe |
| sw_en | input | 1 | Software trigger enable |
| tm_trig | input | 1 | Primary timer trigger strobe |
| tm_en | input | 1 | Primary timer trigger enable |
| tm2_trig | input | 1 | Secondary timer trigger strobe |
| tm2_en | input | 1 | Secondary timer trigger enable |
| trig_out | output | 1 | Merged, aligned acquisition trigger |

## Verification
The bench injects every source at many sample indices and records which delayed word each output pulse meets. A delay line that is one stage too short or too long shows up as an off-by-one word index for that source alone. It sweeps several programmable delays and checks the busy window cycle by cycle, so a counter that fires one cycle early or late, or that restarts on a second event, is caught. Polarity, enable masking and a long-held external level are exercised separately. These catch an edge detector that fires on both edges or on a level, and a disabled source that still starts the delay counter.

// File: rtl/tau_pkg.sv
`timescale 1ns/1ps
package tau_pkg;

  // Number of flops in the external input synchroniser.
  localparam int unsigned SYNC_STAGES = 2;

  // Stages in a source delay line ahead of the shared output register,
  // for a source sampled directly on the clock.
  function automatic int unsigned line_depth(input int unsigned total);
    return total - 1;
  endfunction

  // Same for the external path, whose synchroniser already supplies
  // SYNC_STAGES of the total latency.
  function automatic int unsigned ext_line_depth(input int unsigned total);
    return total - SYNC_STAGES - 1;
  endfunction

endpackage

// File: rtl/tau_pipe.sv
`timescale 1ns/1ps
module tau_pipe #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
        end else begin
          stg[0] <= din;
          for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/tau_ext_front.sv
`timescale 1ns/1ps
module tau_ext_front
  import tau_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_raw,
  input  logic             pol,
  input  logic             en,
  input  logic [CNT_W-1:0] dly,
  output logic             pulse,
  output logic             busy
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl, lvl_q;
  logic                   edge_det;   // one cycle per active transition
  logic                   edge_en;    // edge seen on an enabled input
  logic                   accept;     // edge taken (not busy)
  logic                   fire;       // programmable delay expiring
  logic [CNT_W-1:0]       cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_raw};
      lvl_q  <= lvl;
    end
  end

  assign lvl      = sync_q[SYNC_STAGES-1] ^ pol;
  assign edge_det = lvl & ~lvl_q;
  assign edge_en  = edge_det & en;
  assign busy     = (cnt != '0);
  assign accept   = edge_en & ~busy;
  assign fire     = (cnt == ONE);
  assign pulse    = (accept && dly == '0) || fire;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (accept && dly != '0) cnt <= dly;
    else if (busy)              cnt <= cnt - ONE;
  end

  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > ONE) |=> (cnt == $past(cnt) - ONE));                        // R8
  AST_FIRE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy);                                                   // R7
  AST_BUSY_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(edge_en));                                   // R7
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !busy);                                         // R9
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> !edge_det);                                           // R10

endmodule

// File: rtl/trig_align_unit.sv
`timescale 1ns/1ps
module trig_align_unit
  import tau_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned NCH      = 4,
  parameter int unsigned DATA_DLY = 3,
  parameter int unsigned EXT_COMP = 7,
  parameter int unsigned SW_COMP  = 9,
  parameter int unsigned TM_COMP  = 9,
  parameter int unsigned TM2_COMP = 9,
  parameter int unsigned XDLY_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     samp_in,
  output logic [DW-1:0]     samp_out,
  input  logic [NCH-1:0]    int_trig,
  input  logic [NCH-1:0]    int_en,
  input  logic              ext_in,
  input  logic              ext_pol,
  input  logic              ext_en,
  input  logic [XDLY_W-1:0] ext_dly,
  output logic              ext_busy,
  input  logic              sw_trig,
  input  logic              sw_en,
  input  logic              tm_trig,
  input  logic              tm_en,
  input  logic              tm2_trig,
  input  logic              tm2_en,
  output logic              trig_out
);

  localparam int unsigned EXT_TOTAL = EXT_COMP + DATA_DLY;
  localparam int unsigned INT_DEPTH = line_depth(DATA_DLY);
  localparam int unsigned EXT_DEPTH = ext_line_depth(EXT_TOTAL);
  localparam int unsigned NSTROBE   = 3;   // software, timer, timer 2

  function automatic int unsigned strobe_total(input int unsigned idx);
    case (idx)
      0:       return SW_COMP + DATA_DLY;
      1:       return TM_COMP + DATA_DLY;
      default: return TM2_COMP + DATA_DLY;
    endcase
  endfunction

  // Sample pipeline.
  tau_pipe #(.W(DW), .DEPTH(DATA_DLY)) u_data (
    .clk(clk), .rst_n(rst_n), .din(samp_in), .dout(samp_out));

  // Threshold triggers: slowest path, no extra compensation.
  logic int_any, int_aligned;
  assign int_any = |(int_trig & int_en);
  tau_pipe #(.W(1), .DEPTH(INT_DEPTH)) u_int_line (
    .clk(clk), .rst_n(rst_n), .din(int_any), .dout(int_aligned));

  // External path.
  logic ext_pulse, ext_aligned;
  tau_ext_front #(.CNT_W(XDLY_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .ext_raw(ext_in), .pol(ext_pol), .en(ext_en),
    .dly(ext_dly), .pulse(ext_pulse), .busy(ext_busy));
  tau_pipe #(.W(1), .DEPTH(EXT_DEPTH)) u_ext_line (
    .clk(clk), .rst_n(rst_n), .din(ext_pulse), .dout(ext_aligned));

  // Software and timer strobes, each with its own compensation depth.
  logic [NSTROBE-1:0] strobe_raw, strobe_en, strobe_aligned;
  assign strobe_raw = {tm2_trig, tm_trig, sw_trig};
  assign strobe_en  = {tm2_en, tm_en, sw_en};

  genvar g;
  generate
    for (g = 0; g < NSTROBE; g++) begin : g_strobe
      localparam int unsigned DEPTH_G = line_depth(strobe_total(g));
      logic masked;
      assign masked = strobe_raw[g] & strobe_en[g];
      tau_pipe #(.W(1), .DEPTH(DEPTH_G)) u_line (
        .clk(clk), .rst_n(rst_n), .din(masked), .dout(strobe_aligned[g]));
    end
  endgenerate

  // Merge and register once.
  logic any_aligned;
  assign any_aligned = int_aligned | ext_aligned | (|strobe_aligned);

  always_ff @(posedge clk) begin
    if (!rst_n) trig_out <= 1'b0;
    else        trig_out <= any_aligned;
  end

  AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(any_aligned));                                  // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!trig_out && !ext_busy));                              // R11

endmodule

// File: tb/trig_align_unit_tb.sv
`timescale 1ns/1ps
module trig_align_unit_tb;

  localparam int DW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [DW-1:0] samp_out;
  logic [3:0]  int_trig = '0, int_en = 4'hF;
  logic        ext_in = 1'b0, ext_pol = 1'b0, ext_en = 1'b1;
  logic [31:0] ext_dly = '0;
  logic        ext_busy;
  logic        sw_trig = 1'b0, sw_en = 1'b1;
  logic        tm_trig = 1'b0, tm_en = 1'b1;
  logic        tm2_trig = 1'b0, tm2_en = 1'b1;
  logic        trig_out;

  int tick = 0;
  logic [DW-1:0] samp_in;
  assign samp_in = tick[DW-1:0];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) tick <= tick + 1;

  trig_align_unit u_dut (
    .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .samp_out(samp_out),
    .int_trig(int_trig), .int_en(int_en), .ext_in(ext_in), .ext_pol(ext_pol),
    .ext_en(ext_en), .ext_dly(ext_dly), .ext_busy(ext_busy),
    .sw_trig(sw_trig), .sw_en(sw_en), .tm_trig(tm_trig), .tm_en(tm_en),
    .tm2_trig(tm2_trig), .tm2_en(tm2_en), .trig_out(trig_out));

  int total = 0, fails = 0;
  int nlog = 0;
  logic [DW-1:0] wlog [64];

  always @(negedge clk) begin
    if (rst_n && trig_out) begin
      if (nlog < 64) wlog[nlog] = samp_out;
      nlog = nlog + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_clear;
    idle(40);
    nlog = 0;
  endtask

  // sel: 0..3 threshold channel, 4 software, 5 timer, 6 timer 2
  task automatic strobe(input int sel, output int idx);
    @(negedge clk);
    idx = tick;
    if (sel < 4) int_trig[sel] = 1'b1;
    else if (sel == 4) sw_trig = 1'b1;
    else if (sel == 5) tm_trig = 1'b1;
    else tm2_trig = 1'b1;
    @(negedge clk);
    int_trig = '0; sw_trig = 1'b0; tm_trig = 1'b0; tm2_trig = 1'b0;
  endtask

  task automatic ext_to(input logic v, output int idx);
    @(negedge clk);
    idx = tick;
    ext_in = v;
  endtask

  task automatic expect_one(input int idx, input int off, input string req);
    idle(40);
    check(nlog == 1, req, "pulse count", nlog, 1);
    if (nlog >= 1)
      check(wlog[0] == DW'(idx + off), req, "aligned word", wlog[0], (idx + off) & 16'hFFFF);
    nlog = 0;
  endtask

  task automatic expect_none(input string req);
    idle(40);
    check(nlog == 0, req, "pulse count", nlog, 0);
    nlog = 0;
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int idx, idx2;
    idle(4);
    // R11 / R1 reset state
    check(trig_out == 1'b0, "R11", "trig_out in reset", trig_out, 0);
    check(ext_busy == 1'b0, "R11", "ext_busy in reset", ext_busy, 0);
    check(samp_out == '0, "R1", "samp_out in reset", samp_out, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    check(trig_out == 1'b0 && ext_busy == 1'b0, "R11", "outputs after reset", trig_out, 0);

    // R1 data delay
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(samp_out == DW'(tick - 3), "R1", "data delay", samp_out, (tick - 3) & 16'hFFFF);
    end
    drain_clear();

    // R2, R4, R5 fixed sources at several indices
    for (int rep = 0; rep < 3; rep++) begin
      for (int s = 0; s < 7; s++) begin
        idle(rep * 3 + s);
        strobe(s, idx);
        if (s < 4) expect_one(idx, 0, "R2");
        else if (s == 4) expect_one(idx, 9, "R4");
        else expect_one(idx, 9, "R5");
      end
    end

    // R3 / R7 external with delay sweep, busy window
    for (int d = 0; d < 5; d++) begin
      int n;
      n = (d == 4) ? 13 : d;
      ext_dly = n;
      idle(2);
      ext_to(1'b1, idx);
      for (int k = 1; k <= n + 4; k++) begin
        logic expb;
        @(negedge clk);
        expb = (k >= 3 && k <= n + 2);
        check(ext_busy == expb, "R7", "busy window", ext_busy, expb);
      end
      ext_to(1'b0, idx2);
      expect_one(idx, 7 + n, n == 0 ? "R3" : "R7");
    end

    // R8 second event while busy ignored
    ext_dly = 20;
    ext_to(1'b1, idx);
    idle(3);
    ext_to(1'b0, idx2);
    idle(3);
    ext_to(1'b1, idx2);
    idle(3);
    ext_to(1'b0, idx2);
    idle(30);
    expect_one(idx, 27, "R8");
    ext_dly = 0;

    // R10 long active level gives one pulse
    ext_to(1'b1, idx);
    idle(25);
    ext_to(1'b0, idx2);
    expect_one(idx, 7, "R10");

    // R6 falling-edge polarity
    ext_en = 1'b0;
    @(negedge clk) begin ext_pol = 1'b1; ext_in = 1'b1; end
    idle(6);
    ext_en = 1'b1;
    drain_clear();
    ext_to(1'b0, idx);
    expect_one(idx, 7, "R6");
    ext_to(1'b1, idx);
    expect_none("R6");
    ext_en = 1'b0;
    @(negedge clk) begin ext_pol = 1'b0; ext_in = 1'b0; end
    idle(6);
    ext_en = 1'b1;
    drain_clear();
    // rising-edge polarity: falling transition ignored
    ext_to(1'b1, idx);
    idle(3);
    nlog = 0;
    idle(20);
    nlog = 0;
    ext_to(1'b0, idx);
    expect_none("R6");

    // R9 disabled sources
    ext_en = 1'b0;
    ext_dly = 5;
    ext_to(1'b1, idx);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(ext_busy == 1'b0, "R9", "busy while disabled", ext_busy, 0);
    end
    ext_to(1'b0, idx);
    expect_none("R9");
    ext_en = 1'b1;
    ext_dly = 0;
    sw_en = 1'b0; strobe(4, idx); expect_none("R9");
    sw_en = 1'b1;
    tm_en = 1'b0; strobe(5, idx); expect_none("R9");
    tm_en = 1'b1;
    tm2_en = 1'b0; strobe(6, idx); expect_none("R9");
    tm2_en = 1'b1;
    int_en = 4'b1101; strobe(1, idx); expect_none("R9");
    strobe(0, idx); expect_one(idx, 0, "R2");
    int_en = 4'hF;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule